// File: doc/BRIEF.md
# Row/Column Parity Single-Error Corrector

This block guards an N by N bit data block with 2N check bits: one even-parity bit for each row and one for each column. In encode mode it produces the row and column parities of the block presented on its input. In check mode it receives a stored block together with its stored check bits, recomputes both parity sets and compares them.

The mismatch pattern tells the block what went wrong. If exactly one row and one column disagree, the data bit where they cross is inverted and the repaired block is passed on. A lone row or column mismatch points to a damaged check bit, so the data passes unchanged and fresh check bits are supplied. Any other pattern is reported as uncorrectable. Transfers use a valid/ready handshake on both sides, and the result is registered with one cycle of latency.

Top module: `rcpar_corrector`

## Requirements
- R1: Data bit `in_data[r*N+c]` is the bit at row r, column c. Row check bit r is the XOR of the N bits of row r. Column check bit c is the XOR of the N bits of column c (even parity).
- R2: With `in_mode`=0 (encode), the output carries the input data unchanged and the row and column parities from R1, and all three status flags are 0.
- R3: With `in_mode`=1 (check), if the recomputed parities equal the stored check bits, then data and check bits pass unchanged and all flags are 0.
- R4: In check mode, if exactly one row bit and exactly one column bit mismatch, the data bit at that row and column is inverted, `out_fixed_data`=1, and the stored check bits are passed on.
- R5: In check mode, if exactly one bit mismatches in one dimension and none in the other, the data passes unchanged, the output check bits are the recomputed parities, and `out_fixed_chk`=1.
- R6: In check mode, any other nonzero mismatch pattern sets `out_uncorr`=1, and the data and stored check bits pass unmodified.
- R7: While `out_valid` is 1, at most one of `out_fixed_data`, `out_fixed_chk` and `out_uncorr` is 1.
- R8: `in_ready` equals `!out_valid || out_ready`. An input accepted at a rising edge (with `in_valid` and `in_ready` both high) appears on the outputs with `out_valid`=1 right after that edge. `out_valid` falls after an edge with `out_ready`=1 and no new accept.
- R9: While `out_valid`=1 and `out_ready`=0, all outputs stay unchanged at the next edge.
- R10: A synchronous active-high `rst` clears `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can accept input |
| in_mode | input | 1 | 0 = encode, 1 = check |
| in_data | input | N*N | Data block, row-major |
| in_row_chk | input | N | Stored row check bits (check mode) |
| in_col_chk | input | N | Stored column check bits (check mode) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | N*N | Data, repaired if needed |
| out_row_chk | output | N | Row check bits |
| out_col_chk | output | N | Column check bits |
| out_fixed_data | output | 1 | A data bit was corrected |
| out_fixed_chk | output | 1 | A check bit was regenerated |
| out_uncorr | output | 1 | Uncorrectable pattern detected |

## Verification
A wrong classification or a misplaced flip shows up on the very result that triggered it: one cycle after acceptance, the data carries a wrong bit or a missing correction, or the flags take the wrong value. A fault in the handshake register shows as `out_valid` or `in_ready` departing from the predicted sequence in the next cycle, or as outputs that change while they are held. The stimulus covers clean blocks, single data flips, single check-bit flips in each dimension, double flips and random corruption, all under random backpressure.

// File: rtl/rcpar_pkg.sv
package rcpar_pkg;

  typedef enum logic {
    MODE_ENCODE = 1'b0,
    MODE_CHECK  = 1'b1
  } rcpar_mode_e;

  typedef struct packed {
    logic fixed_data;
    logic fixed_chk;
    logic uncorr;
  } rcpar_flags_t;

endpackage

// File: rtl/rcpar_parity_gen.sv
module rcpar_parity_gen #(
  parameter int N = 8
) (
  input  logic [N*N-1:0] data,
  output logic [N-1:0]   row_par,
  output logic [N-1:0]   col_par
);

  genvar r, c;
  generate
    for (r = 0; r < N; r++) begin : g_row
      assign row_par[r] = ^data[r*N +: N];
    end
    for (c = 0; c < N; c++) begin : g_col
      logic [N-1:0] column_bits;
      for (r = 0; r < N; r++) begin : g_pick
        assign column_bits[r] = data[r*N + c];
      end
      assign col_par[c] = ^column_bits;
    end
  endgenerate

endmodule

// File: rtl/rcpar_classify.sv
module rcpar_classify
  import rcpar_pkg::*;
#(
  parameter int N = 8
) (
  input  rcpar_mode_e    mode,
  input  logic [N-1:0]   row_syn,
  input  logic [N-1:0]   col_syn,
  output rcpar_flags_t   flags,
  output logic           take_calc,
  output logic [N*N-1:0] flip_mask
);

  function automatic logic is_single(input logic [N-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

  logic row_one, col_one, row_none, col_none, pair_hit;

  always_comb begin
    row_one   = is_single(row_syn);
    col_one   = is_single(col_syn);
    row_none  = (row_syn == '0);
    col_none  = (col_syn == '0);
    flags     = '0;
    pair_hit  = 1'b0;
    take_calc = (mode == MODE_ENCODE);
    if (mode == MODE_CHECK) begin
      if (row_none && col_none) begin
        flags = '0;
      end else if (row_one && col_one) begin
        pair_hit         = 1'b1;
        flags.fixed_data = 1'b1;
      end else if ((row_one && col_none) || (row_none && col_one)) begin
        flags.fixed_chk = 1'b1;
        take_calc       = 1'b1;
      end else begin
        flags.uncorr = 1'b1;
      end
    end
  end

  genvar r, c;
  generate
    for (r = 0; r < N; r++) begin : g_r
      for (c = 0; c < N; c++) begin : g_c
        assign flip_mask[r*N + c] = pair_hit & row_syn[r] & col_syn[c];
      end
    end
  endgenerate

endmodule

// File: rtl/rcpar_out_stage.sv
module rcpar_out_stage
  import rcpar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*N-1:0] d_data,
  input  logic [N-1:0]   d_row,
  input  logic [N-1:0]   d_col,
  input  rcpar_flags_t   d_flags,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N*N-1:0] q_data,
  output logic [N-1:0]   q_row,
  output logic [N-1:0]   q_col,
  output rcpar_flags_t   q_flags
);

  logic valid_q;
  logic take;

  assign in_ready  = !valid_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (take) begin
      valid_q <= 1'b1;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_flags <= '0;
    end else if (take) begin
      q_flags <= d_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      q_data <= d_data;
      q_row  <= d_row;
      q_col  <= d_col;
    end
  end

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(q_data) && $stable(q_row)
                                && $stable(q_col) && $stable(q_flags)); // R9

endmodule

// File: rtl/rcpar_corrector.sv
module rcpar_corrector
  import rcpar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_mode,
  input  logic [N*N-1:0] in_data,
  input  logic [N-1:0]   in_row_chk,
  input  logic [N-1:0]   in_col_chk,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N*N-1:0] out_data,
  output logic [N-1:0]   out_row_chk,
  output logic [N-1:0]   out_col_chk,
  output logic           out_fixed_data,
  output logic           out_fixed_chk,
  output logic           out_uncorr
);

  localparam int NBITS = N * N;

  rcpar_mode_e      mode;
  logic [N-1:0]     row_calc, col_calc, row_syn, col_syn;
  logic [N-1:0]     nxt_row, nxt_col;
  logic [NBITS-1:0] flip_mask, nxt_data;
  logic             take_calc;
  rcpar_flags_t     nxt_flags, q_flags;

  assign mode = rcpar_mode_e'(in_mode);

  rcpar_parity_gen #(.N(N)) u_par (
    .data    (in_data),
    .row_par (row_calc),
    .col_par (col_calc)
  );

  assign row_syn = row_calc ^ in_row_chk;
  assign col_syn = col_calc ^ in_col_chk;

  rcpar_classify #(.N(N)) u_cls (
    .mode      (mode),
    .row_syn   (row_syn),
    .col_syn   (col_syn),
    .flags     (nxt_flags),
    .take_calc (take_calc),
    .flip_mask (flip_mask)
  );

  assign nxt_data = in_data ^ flip_mask;
  assign nxt_row  = take_calc ? row_calc : in_row_chk;
  assign nxt_col  = take_calc ? col_calc : in_col_chk;

  rcpar_out_stage #(.N(N)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_data    (nxt_data),
    .d_row     (nxt_row),
    .d_col     (nxt_col),
    .d_flags   (nxt_flags),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_data    (out_data),
    .q_row     (out_row_chk),
    .q_col     (out_col_chk),
    .q_flags   (q_flags)
  );

  assign out_fixed_data = q_flags.fixed_data;
  assign out_fixed_chk  = q_flags.fixed_chk;
  assign out_uncorr     = q_flags.uncorr;

  AST_FLIP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    in_valid && nxt_flags.fixed_data |-> $countones(flip_mask) == 1); // R4

  AST_NO_STRAY_FLIP: assert property (@(posedge clk) disable iff (rst)
    in_valid && !nxt_flags.fixed_data |-> flip_mask == '0); // R5

  AST_ENCODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    in_valid && mode == MODE_ENCODE |-> nxt_flags == '0 && nxt_data == in_data); // R2

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({out_fixed_data, out_fixed_chk, out_uncorr})); // R7

endmodule

// File: tb/rcpar_corrector_tb.sv
module rcpar_corrector_tb;

  localparam int N  = 8;
  localparam int NB = N * N;
  localparam int NUM_VEC = 600;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_mode = 1'b0;
  logic [NB-1:0] in_data = '0;
  logic [N-1:0]  in_row_chk = '0;
  logic [N-1:0]  in_col_chk = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [NB-1:0] out_data;
  logic [N-1:0]  out_row_chk, out_col_chk;
  logic          out_fixed_data, out_fixed_chk, out_uncorr;

  always #2 clk = ~clk;

  rcpar_corrector #(.N(N)) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode),
    .in_data(in_data), .in_row_chk(in_row_chk), .in_col_chk(in_col_chk),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_row_chk(out_row_chk), .out_col_chk(out_col_chk),
    .out_fixed_data(out_fixed_data), .out_fixed_chk(out_fixed_chk),
    .out_uncorr(out_uncorr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_sent = 0;
  int n_acc = 0;
  int cycles = 0;
  bit running = 0;
  bit acc_last = 0;

  logic          m_valid = 1'b0;
  logic          m_held = 1'b0;
  logic [NB-1:0] m_data;
  logic [N-1:0]  m_row, m_col;
  logic [2:0]    m_flags;
  string         m_tag;

  function automatic bit bitat(logic [NB-1:0] d, int r, int c);
    return d[r*N + c];
  endfunction

  task automatic fail_msg(string tag, string what, logic [NB-1:0] act, logic [NB-1:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
  endtask

  task automatic cmp(string tag, string what, logic [NB-1:0] act, logic [NB-1:0] exp);
    n_cmp++;
    if (act !== exp) fail_msg(tag, what, act, exp);
  endtask

  // Behavioural model of one accepted block (R1..R6)
  task automatic model_load(bit md, logic [NB-1:0] d, logic [N-1:0] rc, logic [N-1:0] cc);
    logic [N-1:0] rp, cp, rs, cs;
    int nr, nc, fr, fc;
    rp = '0; cp = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        rp[r] = rp[r] ^ bitat(d, r, c);
        cp[c] = cp[c] ^ bitat(d, r, c);
      end
    m_data = d; m_row = rc; m_col = cc; m_flags = 3'b000;
    if (!md) begin
      m_row = rp; m_col = cp; m_tag = "R1 R2";
      return;
    end
    rs = rp ^ rc; cs = cp ^ cc;
    nr = 0; nc = 0; fr = 0; fc = 0;
    for (int i = 0; i < N; i++) begin
      if (rs[i]) begin nr++; fr = i; end
      if (cs[i]) begin nc++; fc = i; end
    end
    if (nr == 0 && nc == 0) m_tag = "R3";
    else if (nr == 1 && nc == 1) begin
      m_tag = "R4"; m_flags = 3'b100;
      m_data[fr*N + fc] = ~m_data[fr*N + fc];
    end else if ((nr == 1 && nc == 0) || (nr == 0 && nc == 1)) begin
      m_tag = "R5"; m_flags = 3'b010; m_row = rp; m_col = cp;
    end else begin
      m_tag = "R6"; m_flags = 3'b001;
    end
  endtask

  always @(posedge clk) begin
    bit mready;
    acc_last = 0;
    if (rst) begin
      m_valid = 1'b0; m_held = 1'b0;
    end else begin
      mready = !m_valid || out_ready;
      m_held = m_valid && !out_ready;
      if (in_valid && mready) begin
        model_load(in_mode, in_data, in_row_chk, in_col_chk);
        m_valid = 1'b1; acc_last = 1; n_acc++;
      end else if (out_ready) m_valid = 1'b0;
    end
  end

  task automatic gen_vec();
    logic [NB-1:0] d;
    logic [N-1:0] rp, cp;
    int kind, a, b;
    d = {$urandom, $urandom};
    rp = '0; cp = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        rp[r] = rp[r] ^ d[r*N + c];
        cp[c] = cp[c] ^ d[r*N + c];
      end
    kind = $urandom % 8;
    in_mode = (kind != 0);
    in_row_chk = rp; in_col_chk = cp;
    a = $urandom % NB; b = $urandom % NB;
    case (kind)
      2: d[a] = ~d[a];                                   // single data flip
      3: in_row_chk[a % N] = ~in_row_chk[a % N];          // row check flip
      4: in_col_chk[a % N] = ~in_col_chk[a % N];          // column check flip
      5: begin d[a] = ~d[a]; if (b != a) d[b] = ~d[b]; end // double flip
      6: begin in_row_chk = in_row_chk ^ N'($urandom); in_col_chk = in_col_chk ^ N'($urandom); end
      7: begin d[a] = ~d[a]; d[(a/N)*N + (a+1)%N] = ~d[(a/N)*N + (a+1)%N]; end // same row
      default: ;
    endcase
    if (kind == 0) begin in_row_chk = N'($urandom); in_col_chk = N'($urandom); end
    in_data = d;
  endtask

  always @(negedge clk) begin
    if (running) begin
      cmp("R8", "in_ready", NB'(in_ready), NB'(!m_valid || out_ready));
      cmp("R8", "out_valid", NB'(out_valid), NB'(m_valid));
      if (m_valid && out_valid) begin
        cmp(m_held ? "R9" : m_tag, "out_data", out_data, m_data);
        cmp(m_held ? "R9" : m_tag, "out_row_chk", NB'(out_row_chk), NB'(m_row));
        cmp(m_held ? "R9" : m_tag, "out_col_chk", NB'(out_col_chk), NB'(m_col));
        cmp(m_tag, "flags", NB'({out_fixed_data, out_fixed_chk, out_uncorr}), NB'(m_flags));
        n_cmp++;
        if ($countones({out_fixed_data, out_fixed_chk, out_uncorr}) > 1)
          fail_msg("R7", "flag count", NB'({out_fixed_data, out_fixed_chk, out_uncorr}), '0);
      end
      if (!in_valid || acc_last) begin
        if (n_sent < NUM_VEC && ($urandom % 4 != 0)) begin
          gen_vec(); in_valid = 1'b1; n_sent++;
        end else in_valid = 1'b0;
      end
      out_ready = ($urandom % 3 != 0);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R10", "out_valid in reset", NB'(out_valid), '0);
    rst = 1'b0;
    running = 1;
    while (n_acc < NUM_VEC && cycles < 100000) begin
      @(negedge clk);
      cycles++;
    end
    repeat (10) @(negedge clk);
    if (cycles >= 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, 100000);
    end
    running = 0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    cmp("R10", "out_valid after reset", NB'(out_valid), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule